// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that copies a byte count from a source region to a destination region. It uses a simple single-beat memory master port. Software-facing values arrive as plain register inputs: source address, destination address, a control word and a link word. They are loaded by a configuration strobe while the channel is idle. A start pulse makes the channel validate the setup. If the setup is good, the channel alternates reads and writes until the length is used up.

Each side has its own access width (1, 2 or 4 bytes) and its own burst length. Data moves in units of the larger width. Narrow accesses are packed into, or unpacked from, a 32-bit holding word. When a transfer ends, the channel does one of two things. If chaining is on and the current link word does not say stop, it reads a four-word descriptor from memory and runs it. Otherwise it halts.

Each of four event causes sets its own flag. Flags are cleared by writing ones. A mask selects which flags drive the single interrupt line.

Top module: `dma_link_channel`

## Requirements
- R1: After reset the channel is idle (`busy` low), issues no memory request, all four flags are zero and `irq` is low.
- R2: Control word layout: bit 0 enables source increment and bit 1 enables destination increment. Bits 3:2 hold the source width code and bits 5:4 the destination width code, with codes 0,1,2,3 meaning 1,1,2,4 bytes. Bits 8:6 hold the source burst code and bits 11:9 the destination burst code. The low two bits of a burst code give 1,4,8,16 beats. Bits 12 and up hold the byte length. A start is accepted only if source width times source beats equals destination width times destination beats; otherwise flag bit 1 (address error) is set and no memory access is made.
- R3: With bit 2 of a burst code clear, that side's address must be a multiple of its width. With bit 2 set (wrapping burst), it must be a multiple of width times beats. A violation sets flag bit 1 and the transfer does not run.
- R4: The length counts bytes and must be a multiple of the larger of the two widths, else flag bit 1 is set. A length of zero completes without any memory beat.
- R5: A side whose increment enable is clear keeps the same address for every beat. A side whose enable is set advances by its width after each beat.
- R6: Read data is taken from the low byte lanes of `m_rdata` (lowest address in bits 7:0), and write data is presented the same way on `m_wdata`. `m_size` gives log2 of the access bytes (0, 1 or 2), so the destination receives the source bytes in order.
- R7: Link word layout: bits 31:4 hold a 16-byte-aligned descriptor address, bit 1 enables the descriptor-done flag and bit 0 is stop. When a transfer ends with chaining enabled and stop clear, four 32-bit words are read at the descriptor address, +4, +8 and +12, and taken as source, destination, control and link. The new transfer is then validated and run.
- R8: At the end of each transfer, flag bit 0 (descriptor done) is set if the link word's bit 1 is set. If the stop bit is set or chaining is disabled, flag bit 3 (transfer done) is set and the channel goes idle. A configuration written with chaining disabled holds a link word of only the stop bit.
- R9: An error response on a beat sets flag bit 2 (bus error), does not complete that beat, and ends the channel without setting transfer done.
- R10: A stop pulse while busy ends the channel when the current beat is accepted (or at once while it is validating), clears `busy`, and sets no flag.
- R11: `busy` is high from the cycle after an accepted start until the channel ends. A configuration strobe while busy is ignored and answered by a one-cycle `cfg_nack` in the next cycle.
- R12: Writing a one to a bit of `flag_clr` clears that flag, and a flag event in the same cycle wins. `irq` is high exactly when some flag is set whose `irq_en` bit is also set.
- R13: A memory request that is not accepted (`m_ready` low) stays asserted with the same address and direction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load the four configuration values and chain enable |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_ctrl | input | 32 | Control word (increments, widths, bursts, length) |
| cfg_link | input | 32 | Link word (descriptor address, descriptor-flag enable, stop) |
| cfg_link_en | input | 1 | Enable descriptor chaining |
| start | input | 1 | Start the configured transfer |
| stop | input | 1 | Abort at the next beat boundary |
| irq_en | input | 4 | Per-flag interrupt enable |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| flags | output | 4 | Flags: 0 descriptor done, 1 address error, 2 bus error, 3 transfer done |
| irq | output | 1 | Summary interrupt |
| busy | output | 1 | Channel running |
| cfg_nack | output | 1 | Configuration write was refused |
| m_req | output | 1 | Memory request |
| m_wr | output | 1 | Request is a write |
| m_addr | output | AW | Byte address |
| m_size | output | 2 | log2 of access bytes |
| m_wdata | output | 32 | Write data, low lanes |
| m_ready | input | 1 | Request accepted this cycle |
| m_rdata | input | 32 | Read data, low lanes |
| m_err | input | 1 | Error response with m_ready |

## Verification
The main pattern is a sweep over every pairing of source and destination width codes with every pairing of burst codes. In every case a good channel must set the done flag and produce a byte-exact copy exactly when the burst byte counts match, and otherwise set the address-error flag and leave memory alone. The sweep therefore separates the validation rule, the width decoding and the pack/unpack lanes. Targeted cases then use misaligned addresses with and without the wrap bit, fixed source and fixed destination addresses, zero and odd lengths, and a two-descriptor chain. Further cases cover an error response mid-copy, a stop command mid-copy and a configuration written while running. The memory model stalls one cycle in four, so request holding is exercised throughout.

// File: rtl/dma_link_channel.sv
module dma_link_channel #(
  parameter int AW    = 32,
  parameter int LEN_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [31:0]   cfg_ctrl,
  input  logic [31:0]   cfg_link,
  input  logic          cfg_link_en,
  input  logic          start,
  input  logic          stop,
  input  logic [3:0]    irq_en,
  input  logic [3:0]    flag_clr,
  output logic [3:0]    flags,
  output logic          irq,
  output logic          busy,
  output logic          cfg_nack,
  output logic          m_req,
  output logic          m_wr,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  output logic [31:0]   m_wdata,
  input  logic          m_ready,
  input  logic [31:0]   m_rdata,
  input  logic          m_err
);

  localparam int LEN_LSB = 12;
  localparam int F_DESC = 0, F_ADDR = 1, F_BUS = 2, F_DONE = 3;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RD, S_WR, S_END, S_FETCH} st_t;

  st_t           st;
  logic [AW-1:0] src_a, dst_a, fptr;
  logic [31:0]   ctl, lnk, hold;
  logic          lnk_en, stop_pend;
  logic [LEN_W-1:0] rem;
  logic [2:0]    off;
  logic [1:0]    fidx;
  logic [3:0]    fset;

  function automatic logic [2:0] wbytes(input logic [1:0] c);
    return (c == 2'd3) ? 3'd4 : (c == 2'd2) ? 3'd2 : 3'd1;
  endfunction

  function automatic logic [1:0] wlog(input logic [1:0] c);
    return (c == 2'd3) ? 2'd2 : (c == 2'd2) ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [4:0] beats(input logic [1:0] c);
    case (c)
      2'd0: return 5'd1;
      2'd1: return 5'd4;
      2'd2: return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [2:0] n);
    return (n == 3'd4) ? 32'hFFFF_FFFF : (n == 3'd2) ? 32'h0000_FFFF : 32'h0000_00FF;
  endfunction

  wire            s_inc = ctl[0];
  wire            d_inc = ctl[1];
  wire [1:0]      sw_c  = ctl[3:2];
  wire [1:0]      dw_c  = ctl[5:4];
  wire [2:0]      sb_c  = ctl[8:6];
  wire [2:0]      db_c  = ctl[11:9];
  wire [LEN_W-1:0] len  = ctl[LEN_LSB +: LEN_W];

  wire [2:0] sw   = wbytes(sw_c);
  wire [2:0] dw   = wbytes(dw_c);
  wire [2:0] unit = (sw > dw) ? sw : dw;

  wire [6:0] s_burst = 7'(sw * beats(sb_c[1:0]));
  wire [6:0] d_burst = 7'(dw * beats(db_c[1:0]));
  wire [6:0] s_algn  = sb_c[2] ? s_burst : {4'd0, sw};
  wire [6:0] d_algn  = db_c[2] ? d_burst : {4'd0, dw};

  wire s_ok   = (src_a[6:0] & (s_algn - 7'd1)) == 7'd0;
  wire d_ok   = (dst_a[6:0] & (d_algn - 7'd1)) == 7'd0;
  wire len_ok = (len & (LEN_W'(unit) - LEN_W'(1))) == '0;
  wire cfg_ok = (s_burst == d_burst) && s_ok && d_ok && len_ok;

  assign busy  = (st != S_IDLE);
  assign m_req = (st == S_RD) || (st == S_WR) || (st == S_FETCH);
  assign m_wr  = (st == S_WR);
  assign m_addr = (st == S_WR)    ? dst_a :
                  (st == S_FETCH) ? fptr + AW'({fidx, 2'b00}) : src_a;
  assign m_size = (st == S_WR) ? wlog(dw_c) : (st == S_FETCH) ? 2'd2 : wlog(sw_c);
  assign m_wdata = (hold >> {off, 3'b000}) & lane_mask(dw);
  assign irq = |(flags & irq_en);

  wire beat = m_req && m_ready;
  wire good = beat && !m_err;

  always_comb begin
    fset = '0;
    fset[F_DESC] = (st == S_END) && lnk[1];
    fset[F_ADDR] = (st == S_CHECK) && !stop_pend && !cfg_ok;
    fset[F_BUS]  = beat && m_err;
    fset[F_DONE] = (st == S_END) && (lnk[0] || !lnk_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      src_a     <= '0;
      dst_a     <= '0;
      fptr      <= '0;
      ctl       <= '0;
      lnk       <= 32'h1;
      lnk_en    <= 1'b0;
      hold      <= '0;
      rem       <= '0;
      off       <= '0;
      fidx      <= '0;
      stop_pend <= 1'b0;
      flags     <= '0;
      cfg_nack  <= 1'b0;
    end else begin
      flags    <= (flags & ~flag_clr) | fset;
      cfg_nack <= cfg_wr && busy;
      if (stop && busy) stop_pend <= 1'b1;

      if (cfg_wr && !busy) begin
        src_a  <= cfg_src;
        dst_a  <= cfg_dst;
        ctl    <= cfg_ctrl;
        lnk    <= cfg_link_en ? cfg_link : 32'h1;
        lnk_en <= cfg_link_en;
      end

      case (st)
        S_IDLE: begin
          stop_pend <= 1'b0;
          if (start) st <= S_CHECK;
        end
        S_CHECK: begin
          if (stop_pend || stop) st <= S_IDLE;
          else if (!cfg_ok) st <= S_IDLE;
          else if (len == '0) st <= S_END;
          else begin
            rem  <= len;
            off  <= '0;
            hold <= '0;
            st   <= S_RD;
          end
        end
        S_RD: begin
          if (beat && m_err) st <= S_IDLE;
          else if (good) begin
            hold  <= hold | ((m_rdata & lane_mask(sw)) << {off, 3'b000});
            src_a <= src_a + (s_inc ? AW'(sw) : AW'(0));
            if (stop_pend || stop) st <= S_IDLE;
            else if (off + sw == unit) begin
              off <= '0;
              st  <= S_WR;
            end else off <= off + sw;
          end
        end
        S_WR: begin
          if (beat && m_err) st <= S_IDLE;
          else if (good) begin
            dst_a <= dst_a + (d_inc ? AW'(dw) : AW'(0));
            if (stop_pend || stop) st <= S_IDLE;
            else if (off + dw == unit) begin
              off  <= '0;
              hold <= '0;
              rem  <= rem - LEN_W'(unit);
              st   <= (rem == LEN_W'(unit)) ? S_END : S_RD;
            end else off <= off + dw;
          end
        end
        S_END: begin
          if (lnk[0] || !lnk_en) st <= S_IDLE;
          else begin
            fptr <= AW'({lnk[31:4], 4'b0000});
            fidx <= '0;
            st   <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (beat && m_err) st <= S_IDLE;
          else if (good) begin
            case (fidx)
              2'd0: src_a <= AW'(m_rdata);
              2'd1: dst_a <= AW'(m_rdata);
              2'd2: ctl   <= m_rdata;
              default: lnk <= m_rdata;
            endcase
            if (stop_pend || stop) st <= S_IDLE;
            else if (fidx == 2'd3) st <= S_CHECK;
            else fidx <= fidx + 2'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module dma_link_channel_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          m_req,
  input logic          m_wr,
  input logic          m_ready,
  input logic [AW-1:0] m_addr,
  input logic [1:0]    m_size,
  input logic [3:0]    flags,
  input logic          irq,
  input logic          cfg_nack,
  input logic          cfg_wr
);

  // R11
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> busy);

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_wr)));

  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> ((m_size == 2'd2) ? (m_addr[1:0] == 2'b00) :
               (m_size == 2'd1) ? (m_addr[0] == 1'b0) : 1'b1));

  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 4'd0));

  // R11
  nack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_nack |-> $past(cfg_wr && busy));

  // R6
  size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> (m_size != 2'd3));

endmodule

bind dma_link_channel dma_link_channel_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .m_req(m_req), .m_wr(m_wr),
  .m_ready(m_ready), .m_addr(m_addr), .m_size(m_size), .flags(flags),
  .irq(irq), .cfg_nack(cfg_nack), .cfg_wr(cfg_wr)
);

// File: tb/tb_dma_link_channel.sv
`timescale 1ns/1ps
module tb_dma_link_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_link_en = 1'b0, start = 1'b0, stop = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0, cfg_ctrl = '0, cfg_link = '0;
  logic [3:0]  irq_en = '0, flag_clr = '0;
  logic [3:0]  flags;
  logic        irq, busy, cfg_nack, m_req, m_wr;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;
  logic        m_ready, m_err;

  int total = 0, bad = 0;
  int cyc = 0, nbeats = 0, hold_viol = 0;
  logic nack_seen = 1'b0;
  logic err_on = 1'b0;
  logic [31:0] err_addr = '0;
  logic [7:0] mem [0:1023];

  always #2.5 clk = ~clk;

  dma_link_channel dut (.*);

  function automatic logic [7:0] ini(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic int wb(input int c);
    return (c == 3) ? 4 : (c == 2) ? 2 : 1;
  endfunction

  function automatic int bb(input int c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 16;
  endfunction

  function automatic logic [31:0] mkctl(input int si, input int di, input int swc, input int dwc,
                                        input int sbc, input int dbc, input int len);
    return 32'(si) | (32'(di) << 1) | (32'(swc) << 2) | (32'(dwc) << 4) |
           (32'(sbc) << 6) | (32'(dbc) << 9) | (32'(len) << 12);
  endfunction

  // memory responder: one cycle in four stalls
  always @(negedge clk) begin
    m_ready = m_req && ((cyc % 4) != 1);
    m_err   = m_ready && err_on && (m_addr == err_addr);
    m_rdata = {mem[(m_addr[9:0] + 10'd3)], mem[(m_addr[9:0] + 10'd2)],
               mem[(m_addr[9:0] + 10'd1)], mem[m_addr[9:0]]};
  end

  logic        pw;
  logic [31:0] pa;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (m_req && m_ready) nbeats <= nbeats + 1;
    if (m_req && m_ready && m_wr && !m_err)
      for (int k = 0; k < (1 << m_size); k++)
        mem[m_addr[9:0] + 10'(k)] <= m_wdata[k*8 +: 8];
    if (cfg_nack) nack_seen <= 1'b1;
    if (rst_n && pw && (!m_req || m_addr != pa)) hold_viol <= hold_viol + 1;
    pw <= rst_n && m_req && !m_ready;
    pa <= m_addr;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic minit();
    for (int i = 0; i < 1024; i++) mem[i] = ini(i);
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    for (int k = 0; k < 4; k++) mem[a + k] = w[k*8 +: 8];
  endtask

  task automatic cfg(input int s, input int d, input logic [31:0] c, input logic [31:0] l, input logic le);
    @(negedge clk);
    cfg_src = 32'(s); cfg_dst = 32'(d); cfg_ctrl = c; cfg_link = l; cfg_link_en = le; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
  endtask

  task automatic clr_flags();
    @(negedge clk); flag_clr = 4'hF;
    @(negedge clk); flag_clr = 4'h0;
  endtask

  task automatic run(input int s, input int d, input logic [31:0] c, input logic [31:0] l, input logic le);
    clr_flags();
    cfg(s, d, c, l, le);
    nbeats = 0;
    kick();
    wait_idle();
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    minit();
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !m_req && flags == 4'd0 && !irq, "R1 reset state", {busy, m_req, flags, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R6 width/burst sweep
    for (int swc = 0; swc < 4; swc++)
      for (int dwc = 0; dwc < 4; dwc++)
        for (int sbc = 0; sbc < 4; sbc++)
          for (int dbc = 0; dbc < 4; dbc++) begin
            automatic bit valid = (wb(swc) * bb(sbc)) == (wb(dwc) * bb(dbc));
            automatic int mism = 0;
            minit();
            run(32'h100, 32'h200, mkctl(1, 1, swc, dwc, sbc, dbc, 16), 0, 1'b0);
            chk(flags == (valid ? 4'b1000 : 4'b0010), "R2 flags after start",
                flags, valid ? 8 : 2);
            for (int k = 0; k < 16; k++)
              if (mem[32'h200 + k] != (valid ? ini(32'h100 + k) : ini(32'h200 + k))) mism++;
            chk(mism == 0, "R6 copied bytes", mism, 0);
          end

    // R3 alignment
    minit();
    run(32'h102, 32'h200, mkctl(1, 1, 3, 3, 0, 0, 16), 0, 1'b0);
    chk(flags == 4'b0010, "R3 unaligned word source", flags, 2);
    run(32'h102, 32'h200, mkctl(1, 1, 2, 2, 0, 0, 16), 0, 1'b0);
    chk(flags == 4'b1000, "R3 halfword source aligned", flags, 8);
    run(32'h104, 32'h200, mkctl(1, 1, 3, 3, 5, 5, 16), 0, 1'b0);
    chk(flags == 4'b0010, "R3 wrap needs burst alignment", flags, 2);
    run(32'h104, 32'h200, mkctl(1, 1, 3, 3, 1, 1, 16), 0, 1'b0);
    chk(flags == 4'b1000, "R3 same offset without wrap", flags, 8);
    run(32'h110, 32'h200, mkctl(1, 1, 3, 3, 5, 5, 16), 0, 1'b0);
    chk(flags == 4'b1000, "R3 wrap with burst alignment", flags, 8);

    // R4 length rules
    run(32'h100, 32'h200, mkctl(1, 1, 3, 3, 0, 0, 6), 0, 1'b0);
    chk(flags == 4'b0010, "R4 length not multiple of width", flags, 2);
    run(32'h100, 32'h200, mkctl(1, 1, 0, 0, 0, 0, 0), 0, 1'b0);
    chk(flags == 4'b1000 && nbeats == 0, "R4 zero length", nbeats, 0);

    // R5 fixed source
    minit();
    run(32'h100, 32'h200, mkctl(0, 1, 3, 3, 0, 0, 16), 0, 1'b0);
    begin
      automatic int mism = 0;
      for (int k = 0; k < 16; k++) if (mem[32'h200 + k] != ini(32'h100 + (k % 4))) mism++;
      chk(mism == 0 && flags == 4'b1000, "R5 fixed source address", mism, 0);
    end
    // R5 fixed destination
    minit();
    run(32'h100, 32'h200, mkctl(1, 0, 0, 0, 0, 0, 8), 0, 1'b0);
    chk(mem[32'h200] == ini(32'h107) && mem[32'h201] == ini(32'h201),
        "R5 fixed destination address", mem[32'h200], ini(32'h107));

    // R7 R8 two-descriptor chain
    minit();
    put_word(32'h300, 32'h140);
    put_word(32'h304, 32'h240);
    put_word(32'h308, mkctl(1, 1, 0, 0, 0, 0, 8));
    put_word(32'h30C, 32'h3);
    run(32'h100, 32'h200, mkctl(1, 1, 0, 0, 0, 0, 8), 32'h302, 1'b1);
    begin
      automatic int mism = 0;
      for (int k = 0; k < 8; k++) begin
        if (mem[32'h200 + k] != ini(32'h100 + k)) mism++;
        if (mem[32'h240 + k] != ini(32'h140 + k)) mism++;
      end
      chk(mism == 0, "R7 chained descriptor copied", mism, 0);
    end
    chk(flags == 4'b1001, "R8 descriptor and transfer done", flags, 9);

    // R8 stop bit set: no fetch
    minit();
    put_word(32'h300, 32'h140);
    put_word(32'h304, 32'h240);
    put_word(32'h308, mkctl(1, 1, 0, 0, 0, 0, 8));
    put_word(32'h30C, 32'h1);
    run(32'h100, 32'h200, mkctl(1, 1, 0, 0, 0, 0, 8), 32'h301, 1'b1);
    chk(flags == 4'b1000 && mem[32'h240] == ini(32'h240), "R8 stop bit halts chain", flags, 8);

    // R9 bus error
    minit();
    err_on = 1'b1; err_addr = 32'h204;
    run(32'h100, 32'h200, mkctl(1, 1, 0, 0, 0, 0, 16), 0, 1'b0);
    err_on = 1'b0;
    chk(flags == 4'b0100, "R9 bus error flag", flags, 4);
    chk(mem[32'h203] == ini(32'h103) && mem[32'h204] == ini(32'h204), "R9 copy halted",
        mem[32'h204], ini(32'h204));

    // R10 stop command
    minit();
    clr_flags();
    cfg(32'h100, 32'h200, mkctl(1, 1, 0, 0, 0, 0, 64), 0, 1'b0);
    kick();
    repeat (12) @(negedge clk);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    begin
      automatic int n = 0;
      while (busy && n < 10) begin @(negedge clk); n++; end
      chk(!busy, "R10 busy clears after stop", busy, 0);
    end
    chk(flags == 4'd0 && mem[32'h23F] == ini(32'h23F), "R10 abort sets no flag", flags, 0);

    // R11 config refused while busy
    minit();
    nack_seen = 1'b0;
    clr_flags();
    cfg(32'h100, 32'h200, mkctl(1, 1, 0, 0, 0, 0, 32), 0, 1'b0);
    kick();
    repeat (4) @(negedge clk);
    chk(busy, "R11 busy while running", busy, 1);
    cfg(32'h100, 32'h380, mkctl(1, 1, 0, 0, 0, 0, 32), 0, 1'b0);
    @(negedge clk);
    chk(nack_seen, "R11 nack on busy config", nack_seen, 1);
    wait_idle();
    chk(mem[32'h21F] == ini(32'h11F) && mem[32'h380] == ini(32'h380), "R11 config ignored",
        mem[32'h380], ini(32'h380));

    // R12 mask, summary and clear
    irq_en = 4'b0000; @(negedge clk);
    chk(flags == 4'b1000 && !irq, "R12 masked flag no irq", irq, 0);
    irq_en = 4'b1000; @(negedge clk);
    chk(irq, "R12 enabled flag raises irq", irq, 1);
    flag_clr = 4'b0100; @(negedge clk); flag_clr = 4'b0000; @(negedge clk);
    chk(flags == 4'b1000, "R12 clear of other bit", flags, 8);
    flag_clr = 4'b1000; @(negedge clk); flag_clr = 4'b0000; @(negedge clk);
    chk(flags == 4'd0 && !irq, "R12 write one clears", flags, 0);
    irq_en = 4'b0000;

    // R13
    chk(hold_viol == 0, "R13 request held while stalled", hold_viol, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule